// File: doc/BRIEF.md
# Counter-Scan Victim Page Selector

This block chooses which fast-memory page gives up its slot when a slow-memory page is promoted in a hybrid DRAM/NVM memory controller. A small, fully associative redirection table holds, for every fast page, the host page number that currently lives there and the device page number backing it. Any host page may occupy any entry. When a victim is wanted, a scan pointer proposes candidates. The pointer only ever moves forward and wraps around the table. Each candidate is looked up in a counting Bloom filter of recently touched host pages, and a protected candidate is passed over.

Every memory access is reported on the notify port. The filter keeps a sliding window of the most recent accesses. A first-in first-out record of inserted pages lets the oldest page be deleted from the filter when it leaves the window. The filter can report false positives but never false negatives. A search examines at most a fixed number of candidates and then hands out the last one regardless, so it never stalls. After a swap has finished, the controller writes the new host and device page numbers for that entry through the update port.

Top module: `victim_picker`

## Requirements
- R1: After reset `vvld` is low, the scan pointer is at entry 0, and entry i maps host page i to device page i.
- R2: A search starts only when `vreq` is high while no search is running. It ends with `vvld` high for exactly one cycle, carrying `vidx`, `vhost` and `vdev`. A `vreq` that arrives during a running search is ignored and produces no second result.
- R3: One candidate is examined per cycle. An unprotected candidate at the pointer is returned one cycle after the search starts, so `vvld` rises at the second rising edge after `vreq` is sampled.
- R4: After entry j is returned, the next search starts at entry j+1, wrapping from ENTRIES-1 to 0. Skipped candidates also advance the pointer.
- R5: A page reported with `acc_vld` is protected from the following cycle. A table entry whose host page is among the last WINDOW (128) reported pages is never returned, except under R7.
- R6: Once WINDOW newer accesses have been reported after a page's last access, that page is no longer protected (provided none of its counters reached saturation).
- R7: A search examines at most PROBES (8) candidates. If all of them are protected, the eighth is returned, with `vvld` rising at the ninth rising edge after `vreq` is sampled.
- R8: Filter counters are CNT_W (3) bits wide and saturate at 7. A saturated counter is never decremented. A page reported 7 or more times inside one window therefore stays protected after it leaves the window, while a page reported 6 times does not.
- R9: `upd_vld` writes `upd_host` and `upd_dev` into entry `upd_idx`. Searches that start after that cycle see the new values and the new protection status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | An access to `acc_page` is reported this cycle |
| acc_page | input | HPW (20) | Host page number of the reported access |
| vreq | input | 1 | Request a victim |
| vvld | output | 1 | One-cycle pulse: victim fields are valid |
| vidx | output | log2(ENTRIES) (4) | Table index of the victim |
| vhost | output | HPW (20) | Host page held by the victim entry |
| vdev | output | DPW (16) | Device page of the victim entry |
| upd_vld | input | 1 | Write one table entry |
| upd_idx | input | log2(ENTRIES) (4) | Entry to write |
| upd_host | input | HPW (20) | New host page for that entry |
| upd_dev | input | DPW (16) | New device page for that entry |

## Verification
An empty filter shows plain pointer behaviour: the returned index follows the pointer in order and wraps, with a latency of one search cycle. Reporting a single table page separates a working veto from none at all. Reporting every table page shows whether the probe limit forces a return at the eighth candidate. Windows of 127 versus 128 filler accesses locate the exact point of deletion. Repeating a page 6 versus 7 times before the window flushes separates sticky saturation from wrapping or decrementing counters. Table writes, and requests pulsed during a busy search, check the update path and that a running search is not restarted.

// File: rtl/vp_pkg.sv
package vp_pkg;
    localparam int VP_ENTRIES = 16;
    localparam int VP_HPW     = 20;
    localparam int VP_DPW     = 16;
    localparam int VP_SLOTS   = 1024;
    localparam int VP_NHASH   = 5;
    localparam int VP_WINDOW  = 128;
    localparam int VP_CNT_W   = 3;
    localparam int VP_PROBES  = 8;

    typedef enum logic {SEEK_IDLE, SEEK_RUN} seek_e;
endpackage

// File: rtl/vp_filter.sv
module vp_filter #(
    parameter int HPW    = vp_pkg::VP_HPW,
    parameter int SLOTS  = vp_pkg::VP_SLOTS,
    parameter int NHASH  = vp_pkg::VP_NHASH,
    parameter int WINDOW = vp_pkg::VP_WINDOW,
    parameter int CNT_W  = vp_pkg::VP_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_vld,
    input  logic [HPW-1:0]       ins_page,
    input  logic [HPW-1:0]       qry_page,
    output logic                 qry_hit,
    output logic [$clog2(WINDOW+1)-1:0] occupancy
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int WIN_W  = $clog2(WINDOW+1);
    localparam int PTR_W  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // XOR-fold of the page mixed with a rotated copy and a per-function constant.
    function automatic logic [SLOT_W-1:0] fold_hash(input logic [HPW-1:0] pg, input int unsigned sel);
        logic [31:0] w;
        logic [31:0] r;
        logic [SLOT_W-1:0] acc;
        int unsigned sh;
        w  = 32'(pg);
        sh = 5 + 6 * sel;
        r  = (w << sh) | (w >> (32 - sh));
        w  = w ^ r ^ (32'h9E3779B9 >> sel) ^ (32'h7F4A7C15 << sel);
        acc = '0;
        for (int b = 0; b < 32; b++) begin
            acc[b % SLOT_W] = acc[b % SLOT_W] ^ w[b];
        end
        return acc;
    endfunction

    logic [CNT_W-1:0] cnt_q    [SLOTS];
    logic [CNT_W-1:0] cnt_d    [SLOTS];
    logic [HPW-1:0]   fifo_q   [WINDOW];
    logic [HPW-1:0]   fifo_d   [WINDOW];
    logic [PTR_W-1:0] wptr_q, wptr_d;
    logic [WIN_W-1:0] fill_q, fill_d;

    logic [SLOT_W-1:0] h_ins [NHASH];
    logic [SLOT_W-1:0] h_rem [NHASH];
    logic [SLOT_W-1:0] h_qry [NHASH];
    logic              full;
    logic              do_rem;
    logic [HPW-1:0]    old_page;

    always_comb begin
        full     = (fill_q == WIN_W'(WINDOW));
        do_rem   = ins_vld && full;
        old_page = fifo_q[wptr_q];
        for (int k = 0; k < NHASH; k++) begin
            h_ins[k] = fold_hash(ins_page, k);
            h_rem[k] = fold_hash(old_page, k);
            h_qry[k] = fold_hash(qry_page, k);
        end

        qry_hit = 1'b1;
        for (int k = 0; k < NHASH; k++) begin
            if (cnt_q[h_qry[k]] == '0) qry_hit = 1'b0;
        end

        for (int s = 0; s < SLOTS; s++) begin
            logic inc;
            logic dec;
            inc = 1'b0;
            dec = 1'b0;
            for (int k = 0; k < NHASH; k++) begin
                if (ins_vld && h_ins[k] == SLOT_W'(s)) inc = 1'b1;
                if (do_rem  && h_rem[k] == SLOT_W'(s)) dec = 1'b1;
            end
            cnt_d[s] = cnt_q[s];
            if (cnt_q[s] != CMAX) begin
                if (inc && !dec) begin
                    cnt_d[s] = cnt_q[s] + 1'b1;
                end else if (dec && !inc && cnt_q[s] != '0) begin
                    cnt_d[s] = cnt_q[s] - 1'b1;
                end
            end
        end

        fifo_d = fifo_q;
        wptr_d = wptr_q;
        fill_d = fill_q;
        if (ins_vld) begin
            fifo_d[wptr_q] = ins_page;
            wptr_d = (wptr_q == PTR_W'(WINDOW - 1)) ? '0 : wptr_q + 1'b1;
            if (!full) fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) cnt_q[s] <= '0;
            for (int i = 0; i < WINDOW; i++) fifo_q[i] <= '0;
            wptr_q <= '0;
            fill_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            fifo_q <= fifo_d;
            wptr_q <= wptr_d;
            fill_q <= fill_d;
        end
    end

    assign occupancy = fill_q;
endmodule

// File: rtl/vp_table.sv
module vp_table #(
    parameter int ENTRIES = vp_pkg::VP_ENTRIES,
    parameter int HPW     = vp_pkg::VP_HPW,
    parameter int DPW     = vp_pkg::VP_DPW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_vld,
    input  logic [$clog2(ENTRIES)-1:0] upd_idx,
    input  logic [HPW-1:0]             upd_host,
    input  logic [DPW-1:0]             upd_dev,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [HPW-1:0]             rd_host,
    output logic [DPW-1:0]             rd_dev
);
    logic [HPW-1:0] host_q [ENTRIES];
    logic [HPW-1:0] host_d [ENTRIES];
    logic [DPW-1:0] dev_q  [ENTRIES];
    logic [DPW-1:0] dev_d  [ENTRIES];

    always_comb begin
        host_d = host_q;
        dev_d  = dev_q;
        if (upd_vld) begin
            host_d[upd_idx] = upd_host;
            dev_d[upd_idx]  = upd_dev;
        end
        rd_host = host_q[rd_idx];
        rd_dev  = dev_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                host_q[i] <= HPW'(i);
                dev_q[i]  <= DPW'(i);
            end
        end else begin
            host_q <= host_d;
            dev_q  <= dev_d;
        end
    end
endmodule

// File: rtl/vp_scan.sv
module vp_scan
    import vp_pkg::*;
#(
    parameter int ENTRIES = vp_pkg::VP_ENTRIES,
    parameter int HPW     = vp_pkg::VP_HPW,
    parameter int DPW     = vp_pkg::VP_DPW,
    parameter int PROBES  = vp_pkg::VP_PROBES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       cand_hit,
    input  logic [HPW-1:0]             cand_host,
    input  logic [DPW-1:0]             cand_dev,
    output logic [$clog2(ENTRIES)-1:0] cand_idx,
    output logic                       vvld,
    output logic [$clog2(ENTRIES)-1:0] vidx,
    output logic [HPW-1:0]             vhost,
    output logic [DPW-1:0]             vdev,
    output logic                       busy,
    output logic [((PROBES > 1) ? $clog2(PROBES) : 1)-1:0] probe
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PRB_W = (PROBES > 1) ? $clog2(PROBES) : 1;

    typedef struct packed {
        seek_e             mode;
        logic [IDX_W-1:0]  ptr;
        logic [PRB_W-1:0]  probe;
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [HPW-1:0]    host;
        logic [DPW-1:0]    dev;
    } seek_t;

    seek_t s_q, s_d;
    logic [IDX_W-1:0] ptr_next;
    logic             last_probe;

    always_comb begin
        s_d        = s_q;
        s_d.vld    = 1'b0;
        ptr_next   = (s_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.ptr + 1'b1;
        last_probe = (s_q.probe == PRB_W'(PROBES - 1));
        case (s_q.mode)
            SEEK_IDLE: begin
                if (req) begin
                    s_d.mode  = SEEK_RUN;
                    s_d.probe = '0;
                end
            end
            default: begin
                s_d.ptr = ptr_next;
                if (!cand_hit || last_probe) begin
                    s_d.mode = SEEK_IDLE;
                    s_d.vld  = 1'b1;
                    s_d.idx  = s_q.ptr;
                    s_d.host = cand_host;
                    s_d.dev  = cand_dev;
                end else begin
                    s_d.probe = s_q.probe + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: SEEK_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cand_idx = s_q.ptr;
    assign vvld     = s_q.vld;
    assign vidx     = s_q.idx;
    assign vhost    = s_q.host;
    assign vdev     = s_q.dev;
    assign busy     = (s_q.mode == SEEK_RUN);
    assign probe    = s_q.probe;
endmodule

// File: rtl/victim_picker.sv
module victim_picker #(
    parameter int ENTRIES = vp_pkg::VP_ENTRIES,
    parameter int HPW     = vp_pkg::VP_HPW,
    parameter int DPW     = vp_pkg::VP_DPW,
    parameter int SLOTS   = vp_pkg::VP_SLOTS,
    parameter int NHASH   = vp_pkg::VP_NHASH,
    parameter int WINDOW  = vp_pkg::VP_WINDOW,
    parameter int CNT_W   = vp_pkg::VP_CNT_W,
    parameter int PROBES  = vp_pkg::VP_PROBES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_vld,
    input  logic [HPW-1:0]             acc_page,
    input  logic                       vreq,
    output logic                       vvld,
    output logic [$clog2(ENTRIES)-1:0] vidx,
    output logic [HPW-1:0]             vhost,
    output logic [DPW-1:0]             vdev,
    input  logic                       upd_vld,
    input  logic [$clog2(ENTRIES)-1:0] upd_idx,
    input  logic [HPW-1:0]             upd_host,
    input  logic [DPW-1:0]             upd_dev
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PRB_W = (PROBES > 1) ? $clog2(PROBES) : 1;
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic [IDX_W-1:0] cand_idx;
    logic [HPW-1:0]   cand_host;
    logic [DPW-1:0]   cand_dev;
    logic             cand_hit;
    logic             scan_busy;
    logic [PRB_W-1:0] scan_probe;
    logic [WIN_W-1:0] filt_occ;

    vp_table #(.ENTRIES(ENTRIES), .HPW(HPW), .DPW(DPW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .upd_vld(upd_vld), .upd_idx(upd_idx), .upd_host(upd_host), .upd_dev(upd_dev),
        .rd_idx(cand_idx), .rd_host(cand_host), .rd_dev(cand_dev)
    );

    vp_filter #(.HPW(HPW), .SLOTS(SLOTS), .NHASH(NHASH), .WINDOW(WINDOW), .CNT_W(CNT_W)) u_filter (
        .clk(clk), .rst_n(rst_n),
        .ins_vld(acc_vld), .ins_page(acc_page),
        .qry_page(cand_host), .qry_hit(cand_hit), .occupancy(filt_occ)
    );

    vp_scan #(.ENTRIES(ENTRIES), .HPW(HPW), .DPW(DPW), .PROBES(PROBES)) u_scan (
        .clk(clk), .rst_n(rst_n), .req(vreq),
        .cand_hit(cand_hit), .cand_host(cand_host), .cand_dev(cand_dev),
        .cand_idx(cand_idx),
        .vvld(vvld), .vidx(vidx), .vhost(vhost), .vdev(vdev),
        .busy(scan_busy), .probe(scan_probe)
    );
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
    parameter int ENTRIES = 16,
    parameter int PROBES  = 8,
    parameter int WINDOW  = 128
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    vvld,
    input logic [$clog2(ENTRIES)-1:0]              vidx,
    input logic [$clog2(ENTRIES)-1:0]              ptr,
    input logic                                    busy,
    input logic                                    hit,
    input logic [((PROBES > 1) ? $clog2(PROBES) : 1)-1:0] probe,
    input logic [$clog2(WINDOW+1)-1:0]             occ
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PRB_W = (PROBES > 1) ? $clog2(PROBES) : 1;

    logic [15:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= '0;
        else if (busy)  run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vvld |=> !vvld);
    a_r2_only_from_search: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !vvld);
    a_r3_free_candidate_taken: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !hit |=> vvld);
    a_r4_pointer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vvld |-> ptr == ((vidx == IDX_W'(ENTRIES - 1)) ? '0 : vidx + 1'b1));
    a_r5_protected_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hit && probe != PRB_W'(PROBES - 1) |=> !vvld);
    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= ($clog2(WINDOW+1))'(WINDOW));
    a_r7_bounded_search: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 16'(PROBES));
endmodule

bind victim_picker vp_checker #(.ENTRIES(ENTRIES), .PROBES(PROBES), .WINDOW(WINDOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vvld(vvld), .vidx(vidx), .ptr(cand_idx),
    .busy(scan_busy), .hit(cand_hit), .probe(scan_probe), .occ(filt_occ)
);

// File: tb/sim_victim_picker.sv
module sim_victim_picker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_vld;
    logic [19:0] acc_page;
    logic        vreq;
    logic        vvld;
    logic [3:0]  vidx;
    logic [19:0] vhost;
    logic [15:0] vdev;
    logic        upd_vld;
    logic [3:0]  upd_idx;
    logic [19:0] upd_host;
    logic [15:0] upd_dev;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    victim_picker u0 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_page(acc_page),
        .vreq(vreq), .vvld(vvld), .vidx(vidx), .vhost(vhost), .vdev(vdev),
        .upd_vld(upd_vld), .upd_idx(upd_idx), .upd_host(upd_host), .upd_dev(upd_dev)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; acc_vld = 1'b0; acc_page = '0; vreq = 1'b0;
        upd_vld = 1'b0; upd_idx = '0; upd_host = '0; upd_dev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input logic [19:0] pg, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_vld = 1'b1; acc_page = pg;
        end
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    task automatic request(output int lat, output logic [3:0] idx,
                           output logic [19:0] host, output logic [15:0] dev);
        @(negedge clk);
        vreq = 1'b1;
        @(negedge clk);
        vreq = 1'b0;
        lat = 0;
        while (!vvld && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        idx = vidx; host = vhost; dev = vdev;
    endtask

    task automatic t_reset_and_order();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        check(vvld == 1'b0, "R1 vvld low after reset", vvld, 0);
        request(lat, idx, h, d);
        check(idx == 0 && h == 0 && d == 0, "R1 first victim is entry 0 mapping 0->0", {idx, h, d}, 0);
        check(lat == 1, "R3 free candidate latency", lat, 1);
        for (int i = 1; i < 17; i++) begin
            request(lat, idx, h, d);
            check(idx == 4'(i % 16) && h == 20'(i % 16), "R4 pointer order and wrap", idx, i % 16);
        end
    endtask

    task automatic t_protect_one();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        access(20'd0, 1);
        request(lat, idx, h, d);
        check(idx == 1, "R5 recently accessed entry skipped", idx, 1);
        check(lat == 2, "R3 one cycle per candidate", lat, 2);
        request(lat, idx, h, d);
        check(idx == 2, "R4 pointer continues after skip", idx, 2);
    endtask

    task automatic t_all_protected();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        for (int p = 0; p < 16; p++) access(20'(p), 1);
        request(lat, idx, h, d);
        check(idx == 7, "R7 eighth candidate forced", idx, 7);
        check(lat == 8, "R7 bounded search latency", lat, 8);
    endtask

    task automatic t_window();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        access(20'd0, 1);
        access(20'd1000, 127);
        request(lat, idx, h, d);
        check(idx == 1, "R5 page still inside window", idx, 1);
        do_reset();
        access(20'd0, 1);
        access(20'd1000, 128);
        request(lat, idx, h, d);
        check(idx == 0, "R6 page removed after window", idx, 0);
    endtask

    task automatic t_saturate();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        access(20'd0, 6);
        access(20'd1000, 128);
        request(lat, idx, h, d);
        check(idx == 0, "R8 six inserts fully removed", idx, 0);
        do_reset();
        access(20'd0, 7);
        access(20'd1000, 128);
        request(lat, idx, h, d);
        check(idx == 1, "R8 saturated counters stay set", idx, 1);
    endtask

    task automatic t_update();
        int lat; logic [3:0] idx; logic [19:0] h; logic [15:0] d;
        do_reset();
        @(negedge clk);
        upd_vld = 1'b1; upd_idx = 4'd0; upd_host = 20'h5A5A5; upd_dev = 16'h1234;
        @(negedge clk);
        upd_idx = 4'd1; upd_host = 20'hABCDE; upd_dev = 16'h0777;
        @(negedge clk);
        upd_vld = 1'b0;
        request(lat, idx, h, d);
        check(idx == 0 && h == 20'h5A5A5 && d == 16'h1234, "R9 updated entry returned", {idx, h, d}, {4'd0, 20'h5A5A5, 16'h1234});
        access(20'hABCDE, 1);
        request(lat, idx, h, d);
        check(idx == 2, "R9 updated host page protected", idx, 2);
    endtask

    task automatic t_busy_req();
        int pulses;
        do_reset();
        for (int p = 0; p < 16; p++) access(20'(p), 1);
        @(negedge clk); vreq = 1'b1;
        @(negedge clk); vreq = 1'b0;
        pulses = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (i == 2) vreq = 1'b1;
            if (i == 3) vreq = 1'b0;
            if (vvld) begin
                pulses++;
                check(vidx == 7, "R2 single result index", vidx, 7);
            end
        end
        check(pulses == 1, "R2 request during search ignored", pulses, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_and_order();
        t_protect_one();
        t_all_protected();
        t_window();
        t_saturate();
        t_update();
        t_busy_req();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule